// File: doc/BRIEF.md
# Token-Ring Node Status Flag Register

This block keeps the eight-bit status word of a token-passing network node controller and raises that controller's interrupt. The surrounding core sends it single-cycle event strobes: a packet was stored, a transmission finished, an acknowledge came back, the token arrived, a reset happened, or the node ID register was written. The command decoder sends it single-cycle command pulses: enable receive, enable transmit, disable transmitter and clear flags. Each flag is set and cleared by its own fixed pair of events and commands. When a set event and a clearing command arrive in the same cycle, the set event wins, so no event is ever lost.

The block also holds the line idle timer. This timer restarts on every edge of the receive line. If the line stays quiet for the full idle interval, the timer raises the reconfiguration flag. The receiver-inhibited flag also drives a combinational NAK request: while the flag is high, the core refuses any packet addressed to the node. The interrupt output is a registered OR of three flags, each gated by its bit in the interrupt mask. There is no data stream, so every pin is a plain control or status signal.

Top module: `node_status_reg`

## Requirements
- R1: `status_o` bit layout: bit 7 is receiver-inhibited (RI), bit 4 is power-on-reset (POR), bit 2 is reconfiguration (RECON), bit 1 is transmit-acknowledged (TMA) and bit 0 is transmitter-available (TA). Bits 6, 5 and 3 always read 0.
- R2: While `rst_n` is low, and in the first cycle after it rises, `status_o` reads 8'h91 (RI, POR and TA set) and `irq_o` is 0.
- R3: `evt_pkt_stored_i` sets RI. Only `cmd_en_rx_i` clears it. If both occur in the same cycle, RI stays set. The flag changes on the clock edge that samples the strobe.
- R4: `nak_req_o` is high in the same cycle that `pkt_arrive_i` is high while RI is set. It is low whenever RI is clear.
- R5: `sw_reset_i`, or a `node_id_wr_i` cycle with `node_id_data_i` equal to 8'h00, sets POR. A node ID write of any other value has no effect on POR. `cmd_clr_flags_i` clears POR, except in a cycle that also holds a set event.
- R6: After `CLK_MHZ*IDLE_US` clock cycles with no edge on `rx_line_i`, RECON is set. The timer fires once per quiet period and then waits for the next edge. `cmd_clr_flags_i` clears RECON.
- R7: `evt_ack_rx_i` sets TMA unless `evt_tx_bcast_i` is high in the same cycle. `cmd_en_tx_i` clears TMA.
- R8: `evt_tx_done_i` or `cmd_dis_tx_i` sets TA. `cmd_en_tx_i` alone leaves TA unchanged. The first `evt_token_i` in a later cycle clears TA and consumes the pending transmit. `cmd_dis_tx_i` cancels a pending transmit. A token with no pending transmit has no effect. A set event in the same cycle as the token wins.
- R9: `irq_o` equals, one cycle later, (mask[7] & RI) | (mask[2] & RECON) | (mask[0] & TA). The other mask bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| sw_reset_i | input | 1 | Software reset strobe |
| node_id_wr_i | input | 1 | Node ID register write strobe |
| node_id_data_i | input | 8 | Value written to the node ID register |
| evt_pkt_stored_i | input | 1 | Received packet stored in the buffer page |
| evt_tx_done_i | input | 1 | Last byte of the scheduled packet sent |
| evt_ack_rx_i | input | 1 | Acknowledge received for the sent packet |
| evt_tx_bcast_i | input | 1 | Current transmission is a broadcast |
| evt_token_i | input | 1 | Token received by this node |
| rx_line_i | input | 1 | Receive line, watched for activity |
| pkt_arrive_i | input | 1 | Packet addressed to this node is arriving |
| cmd_en_rx_i | input | 1 | Enable-receive command pulse |
| cmd_en_tx_i | input | 1 | Enable-transmit command pulse |
| cmd_dis_tx_i | input | 1 | Disable-transmitter command pulse |
| cmd_clr_flags_i | input | 1 | Clear-flags command pulse |
| irq_mask_i | input | 8 | Interrupt mask, aligned with status bits |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |
| nak_req_o | output | 1 | Refuse the arriving packet |

## Verification
On every cycle, the checker enforces the zero reserved bits, the NAK request, and the registered interrupt equation. It also checks the one-cycle response of RI, POR, TMA and TA to their set and clear pulses, including the rule that a set event beats a clear command. Other behaviours need multi-cycle histories, so only the bench scenarios can show them:
- TA waits for a later token after an enable-transmit.
- Disable-transmitter cancels a pending transmit.
- The idle timer fires once per quiet period near its exact count.
- The full sweep of mask values confirms that the unused mask bits are ignored.

// File: rtl/node_status_pkg.sv
package node_status_pkg;
  localparam int unsigned BIT_RI    = 7;
  localparam int unsigned BIT_POR   = 4;
  localparam int unsigned BIT_RECON = 2;
  localparam int unsigned BIT_TMA   = 1;
  localparam int unsigned BIT_TA    = 0;
  localparam logic [7:0]  IRQ_SRC   = 8'h85;

  typedef struct packed {
    logic ri;
    logic por;
    logic recon;
    logic tma;
    logic ta;
  } nsr_flags_t;
endpackage

// File: rtl/nsr_idle_timer.sv
module nsr_idle_timer #(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned IDLE_US = 82
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic expire_o
);
  localparam int unsigned LIMIT = CLK_MHZ * IDLE_US;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic          line_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          edge_seen;

  assign edge_seen = line_i ^ line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b0;
      armed_q  <= 1'b1;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      line_q   <= line_i;
      expire_o <= 1'b0;
      if (edge_seen) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == CW'(LIMIT - 1)) begin
          cnt_q    <= '0;
          armed_q  <= 1'b0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nsr_flags.sv
module nsr_flags
  import node_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_set_i,
  input  logic       recon_set_i,
  input  logic       pkt_stored_i,
  input  logic       tx_done_i,
  input  logic       ack_i,
  input  logic       bcast_i,
  input  logic       token_i,
  input  logic       en_rx_i,
  input  logic       en_tx_i,
  input  logic       dis_tx_i,
  input  logic       clr_i,
  output nsr_flags_t flags_o
);
  nsr_flags_t f_q;
  logic       tx_pend_q;
  logic       ta_set;
  logic       ta_clr;

  assign ta_set = tx_done_i | dis_tx_i;
  assign ta_clr = tx_pend_q & token_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q       <= '{ri: 1'b1, por: 1'b1, recon: 1'b0, tma: 1'b0, ta: 1'b1};
      tx_pend_q <= 1'b0;
    end else begin
      if (pkt_stored_i)      f_q.ri <= 1'b1;
      else if (en_rx_i)      f_q.ri <= 1'b0;

      if (por_set_i)         f_q.por <= 1'b1;
      else if (clr_i)        f_q.por <= 1'b0;

      if (recon_set_i)       f_q.recon <= 1'b1;
      else if (clr_i)        f_q.recon <= 1'b0;

      if (ack_i && !bcast_i) f_q.tma <= 1'b1;
      else if (en_tx_i)      f_q.tma <= 1'b0;

      if (ta_set)            f_q.ta <= 1'b1;
      else if (ta_clr)       f_q.ta <= 1'b0;

      if (en_tx_i)                    tx_pend_q <= 1'b1;
      else if (dis_tx_i || ta_clr)    tx_pend_q <= 1'b0;
    end
  end

  assign flags_o = f_q;
endmodule

// File: rtl/nsr_irq.sv
module nsr_irq
  import node_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] status_i,
  input  logic [7:0] mask_i,
  output logic       irq_o
);
  logic [7:0] gated;
  assign gated = status_i & mask_i & IRQ_SRC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |gated;
  end
endmodule

// File: rtl/node_status_reg.sv
module node_status_reg
  import node_status_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned IDLE_US = 82
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset_i,
  input  logic       node_id_wr_i,
  input  logic [7:0] node_id_data_i,
  input  logic       evt_pkt_stored_i,
  input  logic       evt_tx_done_i,
  input  logic       evt_ack_rx_i,
  input  logic       evt_tx_bcast_i,
  input  logic       evt_token_i,
  input  logic       rx_line_i,
  input  logic       pkt_arrive_i,
  input  logic       cmd_en_rx_i,
  input  logic       cmd_en_tx_i,
  input  logic       cmd_dis_tx_i,
  input  logic       cmd_clr_flags_i,
  input  logic [7:0] irq_mask_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       nak_req_o
);
  logic       idle_expire;
  logic       por_set;
  nsr_flags_t flags;

  assign por_set = sw_reset_i | (node_id_wr_i && (node_id_data_i == 8'h00));

  nsr_idle_timer #(.CLK_MHZ(CLK_MHZ), .IDLE_US(IDLE_US)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (rx_line_i),
    .expire_o (idle_expire)
  );

  nsr_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_set_i    (por_set),
    .recon_set_i  (idle_expire),
    .pkt_stored_i (evt_pkt_stored_i),
    .tx_done_i    (evt_tx_done_i),
    .ack_i        (evt_ack_rx_i),
    .bcast_i      (evt_tx_bcast_i),
    .token_i      (evt_token_i),
    .en_rx_i      (cmd_en_rx_i),
    .en_tx_i      (cmd_en_tx_i),
    .dis_tx_i     (cmd_dis_tx_i),
    .clr_i        (cmd_clr_flags_i),
    .flags_o      (flags)
  );

  always_comb begin
    status_o            = 8'h00;
    status_o[BIT_RI]    = flags.ri;
    status_o[BIT_POR]   = flags.por;
    status_o[BIT_RECON] = flags.recon;
    status_o[BIT_TMA]   = flags.tma;
    status_o[BIT_TA]    = flags.ta;
  end

  assign nak_req_o = pkt_arrive_i & flags.ri;

  nsr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_o),
    .mask_i   (irq_mask_i),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_reset_i,
  input logic       node_id_wr_i,
  input logic [7:0] node_id_data_i,
  input logic       evt_pkt_stored_i,
  input logic       evt_tx_done_i,
  input logic       evt_ack_rx_i,
  input logic       evt_tx_bcast_i,
  input logic       evt_token_i,
  input logic       pkt_arrive_i,
  input logic       cmd_en_rx_i,
  input logic       cmd_en_tx_i,
  input logic       cmd_dis_tx_i,
  input logic       cmd_clr_flags_i,
  input logic [7:0] irq_mask_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       nak_req_o
);
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  logic por_evt;
  assign por_evt = sw_reset_i | (node_id_wr_i && node_id_data_i == 8'h00);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & 8'h68) == 8'h00);

  assert_nak_on_ri_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_arrive_i && status_o[7]) |-> nak_req_o);

  assert_no_nak_when_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[7] |-> !nak_req_o);

  assert_ri_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkt_stored_i |=> status_o[7]);

  assert_ri_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en_rx_i && !evt_pkt_stored_i) |=> !status_o[7]);

  assert_por_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> status_o[4]);

  assert_por_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_flags_i && !por_evt) |=> !status_o[4]);

  assert_tma_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ack_rx_i && !evt_tx_bcast_i) |=> status_o[1]);

  assert_tma_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_ack_rx_i && !evt_tx_bcast_i) |=> !$rose(status_o[1]));

  assert_ta_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tx_done_i || cmd_dis_tx_i) |=> status_o[0]);

  assert_ta_needs_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_token_i |=> !$fell(status_o[0]));

  assert_irq_equation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> irq_o == $past(|(status_o & irq_mask_i & 8'h85)));
endmodule

bind node_status_reg nsr_checker i_nsr_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .sw_reset_i       (sw_reset_i),
  .node_id_wr_i     (node_id_wr_i),
  .node_id_data_i   (node_id_data_i),
  .evt_pkt_stored_i (evt_pkt_stored_i),
  .evt_tx_done_i    (evt_tx_done_i),
  .evt_ack_rx_i     (evt_ack_rx_i),
  .evt_tx_bcast_i   (evt_tx_bcast_i),
  .evt_token_i      (evt_token_i),
  .pkt_arrive_i     (pkt_arrive_i),
  .cmd_en_rx_i      (cmd_en_rx_i),
  .cmd_en_tx_i      (cmd_en_tx_i),
  .cmd_dis_tx_i     (cmd_dis_tx_i),
  .cmd_clr_flags_i  (cmd_clr_flags_i),
  .irq_mask_i       (irq_mask_i),
  .status_o         (status_o),
  .irq_o            (irq_o),
  .nak_req_o        (nak_req_o)
);

// File: tb/test_node_status_reg.sv
module test_node_status_reg;
  localparam int unsigned T_MHZ = 1;
  localparam int unsigned T_US  = 82;
  localparam int unsigned LIM   = T_MHZ * T_US;

  localparam int unsigned E_PKT = 0, E_DONE = 1, E_ACK = 2, E_BC = 3, E_TOK = 4,
                          E_SWR = 5, E_ENRX = 6, E_ENTX = 7, E_DIS = 8, E_CLR = 9,
                          E_NID = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_reset_i = 0, node_id_wr_i = 0;
  logic [7:0] node_id_data_i = 8'h00;
  logic evt_pkt_stored_i = 0, evt_tx_done_i = 0, evt_ack_rx_i = 0, evt_tx_bcast_i = 0;
  logic evt_token_i = 0, rx_line_i = 0, pkt_arrive_i = 0;
  logic cmd_en_rx_i = 0, cmd_en_tx_i = 0, cmd_dis_tx_i = 0, cmd_clr_flags_i = 0;
  logic [7:0] irq_mask_i = 8'h00;
  logic [7:0] status_o;
  logic irq_o, nak_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  node_status_reg #(.CLK_MHZ(T_MHZ), .IDLE_US(T_US)) i_node_status_reg (
    .clk(clk), .rst_n(rst_n), .sw_reset_i(sw_reset_i), .node_id_wr_i(node_id_wr_i),
    .node_id_data_i(node_id_data_i), .evt_pkt_stored_i(evt_pkt_stored_i),
    .evt_tx_done_i(evt_tx_done_i), .evt_ack_rx_i(evt_ack_rx_i),
    .evt_tx_bcast_i(evt_tx_bcast_i), .evt_token_i(evt_token_i), .rx_line_i(rx_line_i),
    .pkt_arrive_i(pkt_arrive_i), .cmd_en_rx_i(cmd_en_rx_i), .cmd_en_tx_i(cmd_en_tx_i),
    .cmd_dis_tx_i(cmd_dis_tx_i), .cmd_clr_flags_i(cmd_clr_flags_i),
    .irq_mask_i(irq_mask_i), .status_o(status_o), .irq_o(irq_o), .nak_req_o(nak_req_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive a set of strobes for one cycle; returns at the following negedge.
  task automatic pulse(input logic [10:0] ev);
    evt_pkt_stored_i = ev[E_PKT];  evt_tx_done_i   = ev[E_DONE];
    evt_ack_rx_i     = ev[E_ACK];  evt_tx_bcast_i  = ev[E_BC];
    evt_token_i      = ev[E_TOK];  sw_reset_i      = ev[E_SWR];
    cmd_en_rx_i      = ev[E_ENRX]; cmd_en_tx_i     = ev[E_ENTX];
    cmd_dis_tx_i     = ev[E_DIS];  cmd_clr_flags_i = ev[E_CLR];
    node_id_wr_i     = ev[E_NID];
    @(posedge clk);
    @(negedge clk);
    {evt_pkt_stored_i, evt_tx_done_i, evt_ack_rx_i, evt_tx_bcast_i, evt_token_i,
     sw_reset_i, cmd_en_rx_i, cmd_en_tx_i, cmd_dis_tx_i, cmd_clr_flags_i,
     node_id_wr_i} = '0;
  endtask

  function automatic logic [10:0] b(input int unsigned i);
    return 11'(1) << i;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic irq_sweep(input logic [7:0] st, input string tag);
    for (int m = 0; m < 256; m++) begin
      irq_mask_i = 8'(m);
      @(posedge clk);
      @(negedge clk);
      check(tag, {7'd0, irq_o}, {7'd0, |(8'(m) & st & 8'h85)});
    end
    irq_mask_i = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rx_line_i = 0;
    idle(3);
    check("R2 status in reset", status_o, 8'h91);
    check("R2 irq in reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 status after reset", status_o, 8'h91);
    check("R1 reserved bits zero", status_o & 8'h68, 8'h00);

    // R4 / R3: receive gating
    pkt_arrive_i = 1; #1;
    check("R4 nak while RI", {7'd0, nak_req_o}, 8'h01);
    pkt_arrive_i = 0;
    pulse(b(E_ENRX));
    check("R3 enable-rx clears RI", status_o, 8'h11);
    pkt_arrive_i = 1; #1;
    check("R4 no nak when open", {7'd0, nak_req_o}, 8'h00);
    pkt_arrive_i = 0;
    pulse(b(E_PKT));
    check("R3 stored sets RI", status_o, 8'h91);
    pulse(b(E_PKT) | b(E_ENRX));
    check("R3 set wins over enable-rx", status_o, 8'h91);
    pulse(b(E_ENRX));
    check("R3 enable-rx clears RI again", status_o, 8'h11);

    // R5: power-on-reset flag
    pulse(b(E_CLR));
    check("R5 clear-flags clears POR", status_o, 8'h01);
    node_id_data_i = 8'h05;
    pulse(b(E_NID));
    check("R5 nonzero node id ignored", status_o, 8'h01);
    node_id_data_i = 8'h00;
    pulse(b(E_NID));
    check("R5 node id zero sets POR", status_o, 8'h11);
    pulse(b(E_CLR));
    pulse(b(E_SWR));
    check("R5 sw reset sets POR", status_o, 8'h11);
    pulse(b(E_SWR) | b(E_CLR));
    check("R5 set wins over clear", status_o, 8'h11);
    pulse(b(E_CLR));
    check("R5 clear again", status_o, 8'h01);

    // R7 / R8: transmit flags
    pulse(b(E_ENTX));
    check("R8 enable-tx leaves TA", status_o, 8'h01);
    idle(4);
    check("R8 TA waits for token", status_o, 8'h01);
    pulse(b(E_TOK));
    check("R8 token clears TA", status_o, 8'h00);
    pulse(b(E_DONE));
    check("R8 tx done sets TA", status_o, 8'h01);
    pulse(b(E_ACK));
    check("R7 ack sets TMA", status_o, 8'h03);
    pulse(b(E_ENTX));
    check("R7 enable-tx clears TMA", status_o, 8'h01);
    pulse(b(E_ACK) | b(E_BC));
    check("R7 broadcast ack ignored", status_o, 8'h01);
    pulse(b(E_TOK));
    check("R8 token after enable-tx", status_o, 8'h00);
    pulse(b(E_DIS));
    check("R8 disable sets TA", status_o, 8'h01);
    pulse(b(E_TOK));
    check("R8 token without pending ignored", status_o, 8'h01);
    pulse(b(E_ENTX));
    pulse(b(E_DIS));
    pulse(b(E_TOK));
    check("R8 disable cancels pending", status_o, 8'h01);
    pulse(b(E_ENTX) | b(E_TOK));
    check("R8 same-cycle token not counted", status_o, 8'h01);
    pulse(b(E_TOK));
    check("R8 later token clears TA", status_o, 8'h00);
    pulse(b(E_DONE));
    pulse(b(E_ENTX));
    pulse(b(E_TOK) | b(E_DONE));
    check("R8 set wins over token", status_o, 8'h01);
    pulse(b(E_TOK));
    check("R8 pending consumed by token", status_o, 8'h01);

    // R6: line idle timer
    for (int i = 0; i < 3 * LIM; i++) begin
      rx_line_i = ~rx_line_i;
      @(negedge clk);
    end
    check("R6 active line no recon", status_o, 8'h01);
    idle(LIM - 3);
    check("R6 just before timeout", status_o, 8'h01);
    idle(6);
    check("R6 timeout sets RECON", status_o, 8'h05);
    pulse(b(E_CLR));
    check("R6 clear-flags clears RECON", status_o, 8'h01);
    idle(2 * LIM);
    check("R6 one shot per quiet period", status_o, 8'h01);

    // R9: interrupt sweeps over every mask value
    irq_sweep(8'h01, "R9 TA only");
    rx_line_i = ~rx_line_i;
    idle(LIM + 4);
    pulse(b(E_PKT) | b(E_ENTX));
    pulse(b(E_TOK));
    check("R9 setup state", status_o, 8'h84);
    irq_sweep(8'h84, "R9 RI and RECON");
    pulse(b(E_ENRX) | b(E_CLR));
    check("R9 setup quiet state", status_o, 8'h00);
    irq_sweep(8'h00, "R9 no sources");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule